// File: doc/BRIEF.md
# Edge-Interval Logger

This block watches a single one-bit input that is not synchronous to the logging clock. It writes one 32-bit entry into an on-chip record store each time the input level changes. Each entry holds the level the input has just taken and how many clock cycles the previous level lasted. A host reads the entries back through a simple word-addressed port and reads a fill index that tells it how many entries are valid.

The input first passes through a chain of flip-flops clocked by the logging clock. Only the resynchronized level is compared against the last level seen. A single sampling error therefore cannot cause a record with a repeated level or a doubled interval. When the store is full, logging stops and the existing records are kept. A one-cycle clear strobe starts a new capture.

Top module: `edge_interval_logger`

## Requirements
- R1: Each record places the new input level in bit 31 and the interval in bits CNT_W-1:0. Bits 30 down to CNT_W are always 0.
- R2: A record is written only in a cycle where the synchronized level differs from the previously seen level. While the level holds, the fill index does not move.
- R3: The interval stored in a record equals the number of clock cycles between the previous synchronized change and this one. The counter restarts at 1 on a change and otherwise increases by 1 per cycle.
- R4: The interval saturates at 2^CNT_W-1 and does not wrap.
- R5: Once DEPTH records are stored, `full` reads 1 and the fill index stays at DEPTH. Later changes write nothing, and the stored records keep their values.
- R6: Reset or a one-cycle `clear` pulse sets the fill index to 0 and `full` to 0. A steady input produces no record afterwards, including when the input is high while reset is applied.
- R7: The raw input passes through SYNC_STAGES (default 2) flip-flops before comparison. With an input toggling at a fixed period and arbitrary phase, every record alternates in level, and its interval is within one cycle of the applied half-period.
- R8: `rd_data` returns the record at `rd_addr` one clock after the address is presented.
- R9: `fill_idx` equals the number of records written since the last reset or clear, and grows by at most 1 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logging clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear | input | 1 | One-cycle strobe that restarts logging |
| din | input | 1 | Asynchronous level to monitor |
| rd_addr | input | $clog2(DEPTH) | Record index to read |
| rd_data | output | 32 | Record read back, one cycle after the address |
| fill_idx | output | $clog2(DEPTH+1) | Number of stored records |
| full | output | 1 | High when fill_idx equals DEPTH |

## Verification
Holding the input high through reset targets a design whose resynchronizer and last-level register start out of step. Such a design would log a false first entry. Toggles spaced by exact cycle counts expose off-by-one intervals, such as a counter restarting at 0 or a record latched one cycle late. A long hold with a narrow counter shows whether the interval wraps to a small value instead of saturating. Overdriving a small store checks that the index neither passes the depth nor overwrites the last entry. A free-phase toggle stream checks that levels alternate and that intervals stay within one cycle of the applied half-period.

// File: rtl/eil_pkg.sv
package eil_pkg;
  localparam int REC_W   = 32;
  localparam int LVL_BIT = REC_W - 1;
  typedef logic [REC_W-1:0] rec_t;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q, ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = d;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/eil_interval.sv
module eil_interval #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;

  always_comb begin
    if (restart)         cnt_d = ONE;
    else if (cnt == MAX) cnt_d = MAX;
    else                 cnt_d = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= ONE;
    else        cnt <= cnt_d;
  end

  assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !restart) |=> cnt == MAX);
endmodule

// File: rtl/eil_store.sv
module eil_store
  import eil_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rec_t          wdata,
  input  logic [AW-1:0] raddr,
  output rec_t          rdata
);
  rec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/edge_interval_logger.sv
module edge_interval_logger
  import eil_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int CNT_W       = 30,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int IW         = $clog2(DEPTH + 1),
  localparam int WARM       = SYNC_STAGES + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          din,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [IW-1:0] fill_idx,
  output logic          full
);
  logic             lvl_s;
  logic             last_q;
  logic [WARM-1:0]  warm_q;
  logic             ready, hold, changed, we, restart;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    idx_q, idx_d;
  rec_t             wrec;

  eil_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(lvl_s));

  // Warm-up: compare only after the synchronizer has flushed its reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= {warm_q[WARM-2:0], 1'b1};
  end
  assign ready = warm_q[WARM-1];

  assign hold    = clear || !ready;
  assign changed = !hold && (lvl_s != last_q);
  assign full    = (idx_q == IW'(DEPTH));
  assign we      = changed && !full;
  assign restart = hold || changed;

  // The last-seen level follows the synchronized level every cycle: on hold it
  // is reloaded, on a change it takes the new level, otherwise they are equal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= lvl_s;
  end

  eil_interval #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt));

  always_comb begin
    if (clear)   idx_d = '0;
    else if (we) idx_d = idx_q + IW'(1);
    else         idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign wrec = {lvl_s, (REC_W-1)'(cnt)};

  eil_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(idx_q[AW-1:0]),
    .wdata(wrec), .raddr(rd_addr), .rdata(rd_data));

  assign fill_idx = idx_q;

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(DEPTH));
  assert_full_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> $stable(idx_q));
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> idx_q == '0);
  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: tb/tb_edge_interval_logger.sv
`timescale 1ns/1ps
module tb_edge_interval_logger;
  localparam int DEPTH = 8;
  localparam int CNT_W = 6;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = $clog2(DEPTH + 1);
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic          clk = 1'b0;
  logic          rst_n, clear, din;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic [IW-1:0] fill_idx;
  logic          full;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  edge_interval_logger #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .din(din),
    .rd_addr(rd_addr), .rd_data(rd_data), .fill_idx(fill_idx), .full(full));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk) rd_addr = AW'(a);
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic t_reset();
    din = 1'b1; clear = 1'b0; rd_addr = '0; rst_n = 1'b0;
    cyc(3);
    chk(fill_idx == 0, "R6 reset idx", fill_idx, 0);
    chk(full == 1'b0, "R6 reset full", full, 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(10);
    chk(fill_idx == 0, "R6 no spurious record after reset", fill_idx, 0);
  endtask

  task automatic t_exact();
    int h [4] = '{5, 9, 3, 7};
    logic [31:0] r, r0;
    logic lv [5];
    do_clear(); cyc(6);
    for (int k = 0; k < 4; k++) begin
      din = ~din; lv[k] = din;
      cyc(h[k]);
    end
    cyc(10);
    chk(fill_idx == 4, "R9 fill count", fill_idx, 4);
    cyc(20);
    chk(fill_idx == 4, "R2 steady level writes nothing", fill_idx, 4);
    for (int k = 0; k < 4; k++) begin
      rd(k, r);
      chk(r[31] == lv[k], "R1 level bit", r[31], lv[k]);
      chk(r[30:CNT_W] == 0, "R1 upper bits zero", r[30:CNT_W], 0);
      if (k > 0) chk(r[CNT_W-1:0] == h[k-1], "R3 exact interval", r[CNT_W-1:0], h[k-1]);
    end
    // R8: address change shows at the output only after one clock
    rd(0, r0);
    @(negedge clk) rd_addr = AW'(1); #1;
    chk(rd_data == r0, "R8 no early read", rd_data, r0);
    @(posedge clk); #1;
    chk(rd_data[31] == lv[1], "R8 one cycle latency", rd_data[31], lv[1]);
  endtask

  task automatic t_sat();
    logic [31:0] r;
    do_clear(); cyc(4);
    din = ~din; cyc(100);
    din = ~din; cyc(10);
    rd(1, r);
    chk(r[CNT_W-1:0] == MAXV, "R4 saturated interval", r[CNT_W-1:0], MAXV);
  endtask

  task automatic t_async();
    logic [31:0] r;
    logic lv [6];
    do_clear(); cyc(4);
    #($urandom_range(1, 39) / 10.0);
    for (int k = 0; k < 6; k++) begin
      din = ~din; lv[k] = din;
      #22;
    end
    cyc(10);
    chk(fill_idx == 6, "R7 async record count", fill_idx, 6);
    for (int k = 0; k < 6; k++) begin
      rd(k, r);
      chk(r[31] == lv[k], "R7 alternating level", r[31], lv[k]);
      if (k > 0)
        chk(r[CNT_W-1:0] == 5 || r[CNT_W-1:0] == 6, "R7 interval within one cycle",
            r[CNT_W-1:0], 5);
    end
  endtask

  task automatic t_full();
    logic [31:0] r;
    logic lv [12];
    do_clear(); cyc(4);
    for (int k = 0; k < 12; k++) begin
      din = ~din; lv[k] = din;
      cyc(4);
    end
    cyc(10);
    chk(fill_idx == DEPTH, "R5 idx stops at depth", fill_idx, DEPTH);
    chk(full == 1'b1, "R5 full flag", full, 1);
    for (int k = 0; k < DEPTH; k++) begin
      rd(k, r);
      chk(r[31] == lv[k], "R5 records kept", r[31], lv[k]);
      if (k > 0) chk(r[CNT_W-1:0] == 4, "R5 interval kept", r[CNT_W-1:0], 4);
    end
    din = ~din; cyc(4); din = ~din; cyc(10);
    chk(fill_idx == DEPTH, "R5 later edges ignored", fill_idx, DEPTH);
    rd(DEPTH - 1, r);
    chk(r[31] == lv[DEPTH-1], "R5 last record not overwritten", r[31], lv[DEPTH-1]);
  endtask

  task automatic t_clear();
    do_clear();
    chk(fill_idx == 0, "R6 clear idx", fill_idx, 0);
    chk(full == 1'b0, "R6 clear full", full, 0);
    cyc(15);
    chk(fill_idx == 0, "R6 steady after clear", fill_idx, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    summary();
  end

  initial begin
    t_reset();
    t_exact();
    t_sat();
    t_async();
    t_full();
    t_clear();
    summary();
  end
endmodule